// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM array refreshed by issuing CAS-before-RAS refresh cycles. The DRAMs use their own internal row counters, so the block drives no address. A free-running interval timer marks a refresh as due often enough that a full set of row refreshes fits inside the retention period. Each due refresh is added to a saturating debt count. While debt is owed, the block requests the strobe bus from the access sequencer. On a grant it takes over the row strobes, column strobes and write enable. It then runs one refresh cycle on every strobe line at once and releases the bus.

Every strobe phase length is computed in clock cycles from nanosecond parameters and the clock-period parameter. These lengths cover write-enable setup, CAS-to-RAS lead, CAS hold after RAS, RAS low width and RAS precharge. When refreshes are postponed, the owed count grows to a limit. At the limit the block raises an urgent flag that the sequencer must serve before its next access. After reset the block first runs a fixed burst of warm-up refresh cycles and only then reports ready.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, every row strobe, column strobe and the write enable are high. `bus_own`, `ready` and `ref_urgent` are low, and `ref_req` is high because warm-up refreshes are pending.
- R2: After reset release, exactly INIT_CYCLES (8) refresh cycles complete before `ready` rises. `ready` rises in the cycle the last warm-up refresh releases the bus, and it never falls again until reset.
- R3: A refresh becomes due every N = floor(RETENTION_NS*1000 / (ROWS*CLK_PERIOD_PS)) clock cycles. The first is due at the N-th rising edge after reset release. With the grant held high and no debt, consecutive RAS falling edges are exactly N cycles apart.
- R4: While `ref_gnt` is low, no refresh cycle starts. `bus_own` stays low and all strobes stay high.
- R5: One refresh cycle runs in this order, with phase lengths in cycles of ceil(ns*1000/CLK_PERIOD_PS), at least 1:
  - all strobes high for the write-enable setup time;
  - CAS low with RAS high for the CAS-to-RAS lead time;
  - both low for the larger of the CAS hold and write-enable hold times;
  - RAS low with CAS high for the rest of the RAS low width, at least 1 cycle;
  - all strobes high for the precharge time, after which `bus_own` falls.
- R6: All four row strobes carry one value, all four column strobes carry one value, and `we_n` is high throughout every cycle.
- R7: The owed-refresh count saturates at DEBT_MAX (8), and a due refresh that arrives at the limit is lost. `ref_urgent` is high exactly when the count is at the limit and falls when the first refresh completes.
- R8: When the grant returns after D refreshes were postponed, the block runs back-to-back cycles with one idle cycle between them. It runs min(D, 8) cycles plus one for each refresh that falls due during the burst, and then drops `ref_req`.
- R9: `ref_req` is low whenever the block owns the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access sequencer; a refresh starts on an edge where both request and grant are high |
| ref_req | output | 1 | Refresh owed and block idle |
| ref_urgent | output | 1 | Owed count at its limit; the sequencer must serve the request before its next access |
| ready | output | 1 | Warm-up refresh burst finished |
| bus_own | output | 1 | Block drives the strobe bus |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 4 | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The grant is tried in four patterns:
- **Held high from reset.** This separates the warm-up count from ordinary debt and shows the 1-cycle idle gap between back-to-back refreshes.
- **Held high in steady state.** This exposes the interval length as the spacing of RAS falling edges.
- **Withheld for three intervals.** This gives a partial debt below the limit, with no urgent flag.
- **Withheld for twelve intervals.** This must saturate the count, raise the urgent flag and drain exactly eight refreshes plus those that fall due during the drain.

Every refresh cycle seen on the bus is measured phase by phase against lengths computed arithmetically from the timing parameters. This catches any error in strobe ordering or length.

// File: rtl/cbr_pkg.sv
// Shared types and cycle arithmetic for the CAS-before-RAS refresh scheduler.
// Assumes all times are whole nanoseconds and the clock period is in picoseconds.
package cbr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WSET = 3'd1,
        PH_LEAD = 3'd2,
        PH_HOLD = 3'd3,
        PH_RASL = 3'd4,
        PH_PREC = 3'd5
    } phase_t;

    // Nanoseconds to clock cycles, rounded up, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned ps);
        longint unsigned c;
        c = (longint'(ns) * 1000 + longint'(ps) - 1) / longint'(ps);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    // Cycles between due refreshes, rounded down so the period is never exceeded.
    function automatic int unsigned refi_cyc(input int unsigned ret_ns, input int unsigned rows,
                                             input int unsigned ps);
        longint unsigned c;
        c = (longint'(ret_ns) * 1000) / (longint'(rows) * longint'(ps));
        if (c < 2) c = 2;
        return int'(c);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
// Free-running interval timer: pulses due_o for one cycle every PERIOD cycles.
// Assumes PERIOD >= 2. The first pulse occurs on the PERIOD-th edge after reset.
module cbr_interval_timer #(
    parameter int unsigned PERIOD = 1953
) (
    input  logic clk,
    input  logic rst_n,
    output logic due_o
);
    localparam int unsigned CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;

    assign due_o = (cnt_q == CW'(PERIOD - 1));

    // Count up and wrap at PERIOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (due_o) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PERIOD - 1));
endmodule

// File: rtl/cbr_debt_counter.sv
// Saturating count of refreshes that are due but not yet done.
// Assumes inc_i and dec_i are single-cycle pulses; both together leave the count unchanged.
module cbr_debt_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic owed_o,
    output logic full_o
);
    localparam int unsigned DW = $clog2(LIMIT + 1);

    logic [DW-1:0] debt_q;

    assign owed_o = (debt_q != '0);
    assign full_o = (debt_q == DW'(LIMIT));

    // Add due refreshes and remove completed ones, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (!full_o) debt_q <= debt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (owed_o) debt_q <= debt_q - 1'b1;
        end
    end

    // R7
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= DW'(LIMIT));

    // R7
    debt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && inc_i && !dec_i) |=> full_o);
endmodule

// File: rtl/cbr_strobe_seq.sv
// Strobe sequencer: runs one CAS-before-RAS cycle per start pulse.
// Phase lengths arrive in cycles. Assumes start_i is only raised while busy_o is low.
module cbr_strobe_seq
    import cbr_pkg::*;
#(
    parameter int unsigned N_WSET = 2,
    parameter int unsigned N_LEAD = 1,
    parameter int unsigned N_HOLD = 2,
    parameter int unsigned N_RASL = 6,
    parameter int unsigned N_PREC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic ras_low_o,
    output logic cas_low_o,
    output logic done_o
);
    localparam int unsigned N_BIG = max2(max2(max2(N_WSET, N_LEAD), max2(N_HOLD, N_RASL)), N_PREC);
    localparam int unsigned CW    = $clog2(N_BIG + 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;

    // Load value for the phase that follows the current one.
    function automatic logic [CW-1:0] load_of(input phase_t p);
        case (p)
            PH_WSET: load_of = CW'(N_WSET - 1);
            PH_LEAD: load_of = CW'(N_LEAD - 1);
            PH_HOLD: load_of = CW'(N_HOLD - 1);
            PH_RASL: load_of = CW'(N_RASL - 1);
            PH_PREC: load_of = CW'(N_PREC - 1);
            default: load_of = '0;
        endcase
    endfunction

    // Fixed order of the refresh phases.
    function automatic phase_t next_of(input phase_t p);
        case (p)
            PH_WSET: next_of = PH_LEAD;
            PH_LEAD: next_of = PH_HOLD;
            PH_HOLD: next_of = PH_RASL;
            PH_RASL: next_of = PH_PREC;
            default: next_of = PH_IDLE;
        endcase
    endfunction

    // Step through the phases, each lasting its own cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (start_i) begin
                ph_q  <= PH_WSET;
                cnt_q <= load_of(PH_WSET);
            end
        end else if (cnt_q == '0) begin
            ph_q  <= next_of(ph_q);
            cnt_q <= load_of(next_of(ph_q));
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Decode strobe levels from the current phase.
    always_comb begin
        busy_o    = (ph_q != PH_IDLE);
        cas_low_o = (ph_q == PH_LEAD) || (ph_q == PH_HOLD);
        ras_low_o = (ph_q == PH_HOLD) || (ph_q == PH_RASL);
        done_o    = (ph_q == PH_PREC) && (cnt_q == '0);
    end

    // R5
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_low_o) |-> $past(cas_low_o) && cas_low_o);

    // R5
    prec_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(ras_low_o) && !$past(cas_low_o));
endmodule

// File: rtl/cbr_refresh_sched.sv
// CAS-before-RAS refresh scheduler top.
// An interval timer feeds an owed-refresh count; a warm-up burst runs after reset.
// A request/grant handshake hands the strobe bus to the sequencer for one refresh at a time.
// Assumes the access sequencer stops driving the strobes whenever bus_own is high.
module cbr_refresh_sched
    import cbr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned RETENTION_NS  = 16000000,
    parameter int unsigned ROWS          = 1024,
    parameter int unsigned T_RAS_NS      = 60,
    parameter int unsigned T_RP_NS       = 40,
    parameter int unsigned T_CSR_NS      = 5,
    parameter int unsigned T_CHR_NS      = 10,
    parameter int unsigned T_WSU_NS      = 10,
    parameter int unsigned T_WHD_NS      = 10,
    parameter int unsigned DEBT_MAX      = 8,
    parameter int unsigned INIT_CYCLES   = 8,
    parameter int unsigned N_RAS_LINES   = 4,
    parameter int unsigned N_CAS_LINES   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_gnt,
    output logic                   ref_req,
    output logic                   ref_urgent,
    output logic                   ready,
    output logic                   bus_own,
    output logic [N_RAS_LINES-1:0] ras_n,
    output logic [N_CAS_LINES-1:0] cas_n,
    output logic                   we_n
);
    localparam int unsigned N_REFI = refi_cyc(RETENTION_NS, ROWS, CLK_PERIOD_PS);
    localparam int unsigned N_WSET = ns_to_cyc(T_WSU_NS, CLK_PERIOD_PS);
    localparam int unsigned N_LEAD = ns_to_cyc(T_CSR_NS, CLK_PERIOD_PS);
    localparam int unsigned N_HOLD = max2(ns_to_cyc(T_CHR_NS, CLK_PERIOD_PS),
                                          ns_to_cyc(T_WHD_NS, CLK_PERIOD_PS));
    localparam int unsigned N_RAS  = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
    localparam int unsigned N_RASL = (N_RAS > N_HOLD) ? (N_RAS - N_HOLD) : 1;
    localparam int unsigned N_PREC = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned IW     = $clog2(INIT_CYCLES + 1);

    logic          due;
    logic          owed;
    logic          full;
    logic          busy;
    logic          ras_low;
    logic          cas_low;
    logic          done;
    logic          start;
    logic          debt_dec;
    logic [IW-1:0] init_q;

    cbr_interval_timer #(.PERIOD(N_REFI)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .due_o (due)
    );

    cbr_debt_counter #(.LIMIT(DEBT_MAX)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (due),
        .dec_i  (debt_dec),
        .owed_o (owed),
        .full_o (full)
    );

    cbr_strobe_seq #(
        .N_WSET (N_WSET),
        .N_LEAD (N_LEAD),
        .N_HOLD (N_HOLD),
        .N_RASL (N_RASL),
        .N_PREC (N_PREC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .busy_o    (busy),
        .ras_low_o (ras_low),
        .cas_low_o (cas_low),
        .done_o    (done)
    );

    // Warm-up refreshes consume completions before ordinary debt does.
    always_ff @(posedge clk) begin
        if (!rst_n)                     init_q <= IW'(INIT_CYCLES);
        else if (done && init_q != '0)  init_q <= init_q - 1'b1;
    end

    // Handshake and status decode.
    always_comb begin
        debt_dec   = done && (init_q == '0);
        ready      = (init_q == '0);
        ref_req    = (owed || (init_q != '0)) && !busy;
        start      = ref_req && ref_gnt;
        ref_urgent = full;
        bus_own    = busy;
        we_n       = 1'b1;
    end

    // Drive every row strobe identically.
    for (genvar gr = 0; gr < N_RAS_LINES; gr++) begin : g_ras
        assign ras_n[gr] = !ras_low;
    end

    // Drive every column strobe identically.
    for (genvar gc = 0; gc < N_CAS_LINES; gc++) begin : g_cas
        assign cas_n[gc] = !cas_low;
    end

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R9
    no_req_while_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> !ref_req);

    // R4
    no_start_without_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_own && !ref_gnt) |=> !bus_own);

    // R6
    ras_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == '0) || (ras_n == '1));

    // R6
    cas_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1));

    // R5
    ras_fall_cas_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n[0]) |-> (cas_n == '0));
endmodule

// File: tb/cbr_refresh_sched_tb_top.sv
// Bench for the refresh scheduler with a shortened retention period (50-cycle interval).
module cbr_refresh_sched_tb_top;
    localparam int CLK_PS = 8000;
    localparam int ROWS   = 1024;
    localparam int RET_NS = 409600;
    localparam int N      = (RET_NS * 1000) / (ROWS * CLK_PS);
    localparam int LIM    = 8;
    localparam int E_WSET = (10 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_LEAD = (5 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_HOLD = (10 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RAS  = (60 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RASL = (E_RAS > E_HOLD) ? E_RAS - E_HOLD : 1;
    localparam int E_PREC = (40 * 1000 + CLK_PS - 1) / CLK_PS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ref_req, ref_urgent, ready, bus_own, we_n;
    logic [3:0] ras_n, cas_n;

    int tests = 0;
    int fails = 0;
    int k = 0;
    int idle_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    cbr_refresh_sched #(
        .CLK_PERIOD_PS (CLK_PS),
        .RETENTION_NS  (RET_NS),
        .ROWS          (ROWS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .ready      (ready),
        .bus_own    (bus_own),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Rising edges since reset release.
    always @(posedge clk) begin
        if (rst_n) k = k + 1;
        else       k = 0;
    end

    // Phase-length monitor for every refresh cycle on the bus.
    int  p0, p1, p2, p3, p4;
    bit  seen_ras, bad_lines, own_p;
    always @(negedge clk) begin
        if (!rst_n) begin
            p0 = 0; p1 = 0; p2 = 0; p3 = 0; p4 = 0;
            seen_ras = 0; bad_lines = 0; own_p = 0;
        end else begin
            if (bus_own) begin
                if (!((ras_n == 4'h0 || ras_n == 4'hF) && (cas_n == 4'h0 || cas_n == 4'hF) && we_n))
                    bad_lines = 1;
                if (ras_n[0] == 1'b0) seen_ras = 1;
                if (ras_n[0] && cas_n[0] && !seen_ras) p0++;
                else if (ras_n[0] && !cas_n[0])        p1++;
                else if (!ras_n[0] && !cas_n[0])       p2++;
                else if (!ras_n[0] && cas_n[0])        p3++;
                else                                   p4++;
                // R9 request is low while owning
                if (ref_req) check(0, "R9", 1, 0);
            end else begin
                if (ras_n != 4'hF || cas_n != 4'hF || !we_n) idle_bad++;
            end
            if (own_p && !bus_own) begin
                // R5 phase order and lengths
                check(p0 == E_WSET, "R5 wset", p0, E_WSET);
                check(p1 == E_LEAD, "R5 lead", p1, E_LEAD);
                check(p2 == E_HOLD, "R5 hold", p2, E_HOLD);
                check(p3 == E_RASL, "R5 rasl", p3, E_RASL);
                check(p4 == E_PREC, "R5 prec", p4, E_PREC);
                // R6 lines uniform, we_n high
                check(!bad_lines, "R6", int'(bad_lines), 0);
                p0 = 0; p1 = 0; p2 = 0; p3 = 0; p4 = 0;
                seen_ras = 0; bad_lines = 0;
            end
            own_p = bus_own;
        end
    end

    task automatic wait_quiet();
        do @(negedge clk); while (bus_own || ref_req);
    endtask

    // Withhold the grant, then grant and count the drain burst (R4, R7, R8).
    task automatic starve_and_drain(input int intervals);
        int ks, kg, ts, d0, c, kend, exp_c, idle_before;
        bit own_q, first_done;
        wait_quiet();
        ref_gnt = 1'b0;
        ks = k;
        idle_before = idle_bad;
        repeat (intervals * N) begin
            @(negedge clk);
            if (bus_own) idle_before = -1;
        end
        while ((k % N) != 0) @(negedge clk);
        kg = k;
        ts = kg / N - ks / N;
        d0 = (ts > LIM) ? LIM : ts;
        // R4 no activity without grant
        check(idle_before == idle_bad, "R4", idle_bad, idle_before);
        check(ref_req == (d0 > 0), "R8 req", int'(ref_req), int'(d0 > 0));
        // R7 urgent exactly at the limit
        check(ref_urgent == (d0 == LIM), "R7 urgent", int'(ref_urgent), int'(d0 == LIM));
        ref_gnt = 1'b1;
        c = 0; own_q = 0; first_done = 0;
        forever begin
            @(negedge clk);
            if (bus_own && !own_q) c++;
            if (!bus_own && own_q && !first_done) begin
                first_done = 1;
                // R7 urgent falls after the first completion
                check(ref_urgent == 1'b0, "R7 drop", int'(ref_urgent), 0);
            end
            own_q = bus_own;
            if (!bus_own && !ref_req) break;
        end
        kend = k;
        exp_c = d0 + (kend / N - kg / N);
        // R8 burst length
        check(c == exp_c, "R8 burst", c, exp_c);
    endtask

    initial begin
        int cnt;
        bit own_q;
        int t_prev;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(ras_n == 4'hF && cas_n == 4'hF && we_n, "R1 strobes", {ras_n, cas_n}, 8'hFF);
        check(!bus_own, "R1 own", int'(bus_own), 0);
        check(!ready, "R1 ready", int'(ready), 0);
        check(!ref_urgent, "R1 urgent", int'(ref_urgent), 0);
        check(ref_req, "R1 req", int'(ref_req), 1);

        rst_n = 1'b1;
        ref_gnt = 1'b1;
        // R2 warm-up burst
        cnt = 0; own_q = 0;
        do begin
            @(negedge clk);
            if (bus_own && !own_q) cnt++;
            own_q = bus_own;
        end while (!ready);
        check(cnt == 8, "R2 count", cnt, 8);
        check(!bus_own, "R2 release", int'(bus_own), 0);

        // R3 steady-state spacing
        wait_quiet();
        t_prev = -1;
        cnt = 0;
        own_q = 1;
        while (cnt < 4) begin
            @(negedge clk);
            if (own_q && !ras_n[0]) begin
                if (t_prev >= 0) check(k - t_prev == N, "R3 spacing", k - t_prev, N);
                t_prev = k;
                cnt++;
            end
            own_q = ras_n[0];
        end

        starve_and_drain(3);
        starve_and_drain(12);
        // R2 ready stays high
        check(ready, "R2 sticky", int'(ready), 1);
        // R4 strobes idle whenever the bus is not owned
        check(idle_bad == 0, "R4 idle", idle_bad, 0);

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule